// File: doc/BRIEF.md
# Bitstream Window with Start-Code Seek

This block is the bit-level front end of a variable-length decoder. A host sets a byte address and a byte length. The block then pulls the compressed stream one byte at a time from a simple request/grant memory port into a small holding buffer. It always shows the host the next 16 bits of the stream, aligned to the current bit position. The host moves through the stream in one of two ways. It can consume a given number of bits, or it can ask the block to seek forward in hardware to the next start code.

A start code is a byte-aligned run of two or more zero bytes followed by a 0x01 byte. When the seek finds one, the block stops and raises a sticky status flag. It then refuses all commands until the host clears that flag. Two more sticky flags report that the programmed bytes have all been fetched, and that a command needed bits the exhausted buffer could not supply. Each flag has its own interrupt enable, and the interrupt output is high whenever an enabled flag is set.

Top module: `bitstream_window`

## Requirements
- R1: `win_data` holds the 16 stream bits that start at the current bit position, first bit at bit 15. `win_full` is high exactly when at least 16 fetched bits lie at or beyond that position.
- R2: A shift command (`cmd_op` = 1) advances the position by `cmd_bits`. It is taken only when `win_full` is high, no seek is running and the start-code flag is clear. A count of 0 leaves the window unchanged, and a count above 16 is ignored.
- R3: A seek command (`cmd_op` = 2; 0 means no command) first skips to the next byte boundary. It then consumes whole bytes until it has consumed a 0x01 byte that follows two or more 0x00 bytes. `seek_busy` is high while the seek runs.
- R4: When the seek completes, `status[0]` (start code found) is set and `seek_busy` goes low. The window is then byte-aligned, with its upper 8 bits equal to the byte that follows the 0x01.
- R5: While `status[0]` is set, shift and seek commands have no effect on the window or on `seek_busy`.
- R6: Status bits are cleared by writing one: a pulse on `sts_clr_we` clears every bit set in `sts_clr`, and a set condition in the same cycle wins. `ien_we` loads the enables from `ien_wdata`. `irq` is the OR of status bits whose enable is 1, and it stays low while all enables are 0.
- R7: A pulse on `cfg_load` takes the start address and byte length, empties the holding buffer and resets the bit position. `status[1]` is set when the last programmed byte is fetched.
- R8: A byte is requested (`mem_req`) only while fewer than 24 valid bits are held and bytes remain. It is taken in a cycle where `mem_req` and `mem_gnt` are both high, and the holding buffer never exceeds 32 bits.
- R9: `mem_addr` starts at the loaded address and rises by one after each byte taken.
- R10: If a command needs more bits than the buffer holds and no programmed bytes remain, `status[2]` (stall) is set and the command waits. For a shift this means fewer than 16 bits; for a seek step, fewer than the bits that step needs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load address and length, flush the buffer |
| cfg_addr | input | 32 | Byte start address |
| cfg_len | input | 16 | Buffer length in bytes |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 none, 1 shift, 2 seek |
| cmd_bits | input | 5 | Shift amount in bits |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr | input | 3 | Write-one-to-clear mask |
| ien_we | input | 1 | Interrupt-enable write strobe |
| ien_wdata | input | 3 | Interrupt enables |
| mem_req | output | 1 | Byte request |
| mem_addr | output | 32 | Byte address |
| mem_gnt | input | 1 | Byte grant; data valid when high |
| mem_byte | input | 8 | Granted byte |
| win_data | output | 16 | Look-ahead window |
| win_full | output | 1 | Window holds 16 valid bits |
| seek_busy | output | 1 | Seek in progress |
| status | output | 3 | bit0 start code, bit1 input done, bit2 stall |
| irq | output | 1 | Interrupt |

## Verification
A shift presented in one cycle moves the window at the next clock edge. The refill that follows can take more cycles, depending on the grant pattern. So after each command the bench waits, one falling edge at a time, until `win_full` is high, and only then compares the window with the bit string computed from its own stream function. Status flags are registered one edge after the event that sets them, and `irq` follows them in the same cycle. The bench therefore samples the flags and the interrupt at the falling edge after the command or clear strobe is dropped, and waits on `status[0]` for a seek, whose length depends on the stream.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_SEEK  = 2'd2
  } bsw_op_e;

  typedef enum logic {
    CS_IDLE = 1'b0,
    CS_SEEK = 1'b1
  } bsw_state_e;

  localparam int ST_SC    = 0;
  localparam int ST_DONE  = 1;
  localparam int ST_STALL = 2;
  localparam int ST_N     = 3;
endpackage

// File: rtl/bsw_fetch.sv
module bsw_fetch #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [LEN_W-1:0]  load_len,
  input  logic              want,
  input  logic              mem_gnt,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              take,
  output logic              empty,
  output logic              drained
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic              en;

  assign empty   = (left_q == '0);
  assign mem_req = want & ~empty & ~load;
  assign take    = mem_req & mem_gnt;
  assign drained = take & (left_q == LEN_W'(1));
  assign mem_addr = addr_q;

  always_comb begin
    addr_d = addr_q;
    left_d = left_q;
    en     = 1'b0;
    if (load) begin
      addr_d = load_addr;
      left_d = load_len;
      en     = 1'b1;
    end else if (take) begin
      addr_d = addr_q + ADDR_W'(1);
      left_d = left_q - LEN_W'(1);
      en     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= '0;
    end else if (en) begin
      addr_q <= addr_d;
      left_q <= left_d;
    end
  end

  assert_addr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  assert_req_has_bytes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ($past(left_q) - LEN_W'(1) == left_q));
endmodule

// File: rtl/bsw_holdbuf.sv
module bsw_holdbuf #(
  parameter int BUF_W  = 32,
  parameter int WIN_W  = 16,
  parameter int SHW    = 5,
  parameter int FILL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [SHW-1:0]    shamt,
  input  logic              append,
  input  logic [7:0]        byte_in,
  output logic [WIN_W-1:0]  win,
  output logic [7:0]        top_byte,
  output logic [FILL_W-1:0] fill
);
  logic [BUF_W-1:0]  buf_q, buf_d, shifted, placed;
  logic [FILL_W-1:0] fill_q, fill_d, fill_sh;
  logic              en;

  assign win      = buf_q[BUF_W-1 -: WIN_W];
  assign top_byte = buf_q[BUF_W-1 -: 8];
  assign fill     = fill_q;

  always_comb begin
    shifted = buf_q << shamt;
    fill_sh = fill_q - FILL_W'(shamt);
    placed  = {byte_in, {(BUF_W-8){1'b0}}} >> fill_sh;
    en      = flush | append | (shamt != '0);
    if (flush) begin
      buf_d  = '0;
      fill_d = '0;
    end else if (append) begin
      buf_d  = shifted | placed;
      fill_d = fill_sh + FILL_W'(8);
    end else begin
      buf_d  = shifted;
      fill_d = fill_sh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      fill_q <= '0;
    end else if (en) begin
      buf_q  <= buf_d;
      fill_q <= fill_d;
    end
  end

  assert_fill_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FILL_W'(BUF_W));

  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    FILL_W'(shamt) <= fill_q);
endmodule

// File: rtl/bsw_ctrl.sv
module bsw_ctrl
  import bsw_pkg::*;
#(
  parameter int WIN_W  = 16,
  parameter int SHW    = 5,
  parameter int FILL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [SHW-1:0]    cmd_bits,
  input  logic [FILL_W-1:0] fill,
  input  logic [7:0]        top_byte,
  input  logic              halted,
  input  logic              empty,
  output logic [SHW-1:0]    shamt,
  output logic              found,
  output logic              seeking,
  output logic              stall_evt
);
  localparam logic [SHW-1:0]    SH_LIM   = SHW'(WIN_W);
  localparam logic [FILL_W-1:0] FILL_WIN = FILL_W'(WIN_W);
  localparam logic [FILL_W-1:0] FILL_BYTE = FILL_W'(8);

  bsw_state_e st_q, st_d;
  logic [1:0] zrun_q, zrun_d;
  logic [2:0] bitpos_q, bitpos_d;
  logic [2:0] align_n;
  logic       en;

  assign seeking = (st_q == CS_SEEK);
  assign align_n = 3'd0 - bitpos_q;

  always_comb begin
    st_d      = st_q;
    zrun_d    = zrun_q;
    shamt     = '0;
    found     = 1'b0;
    stall_evt = 1'b0;
    if (!flush) begin
      if (st_q == CS_IDLE) begin
        if (cmd_valid && !halted) begin
          if (cmd_op == OP_SHIFT && cmd_bits <= SH_LIM) begin
            if (fill >= FILL_WIN) shamt = cmd_bits;
            else if (empty)       stall_evt = 1'b1;
          end else if (cmd_op == OP_SEEK) begin
            st_d   = CS_SEEK;
            zrun_d = 2'd0;
          end
        end
      end else begin
        if (align_n != 3'd0) begin
          if (fill >= FILL_W'(align_n)) shamt = SHW'(align_n);
          else if (empty)                stall_evt = 1'b1;
        end else if (fill >= FILL_BYTE) begin
          shamt = SHW'(8);
          if (zrun_q == 2'd2 && top_byte == 8'h01) begin
            found = 1'b1;
            st_d  = CS_IDLE;
          end else if (top_byte == 8'h00) begin
            zrun_d = (zrun_q == 2'd2) ? 2'd2 : zrun_q + 2'd1;
          end else begin
            zrun_d = 2'd0;
          end
        end else if (empty) begin
          stall_evt = 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (flush) begin
      bitpos_d = 3'd0;
      en       = 1'b1;
    end else begin
      bitpos_d = bitpos_q + shamt[2:0];
      en       = (shamt != '0) || (st_d != st_q) || (zrun_d != zrun_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= CS_IDLE;
      zrun_q   <= 2'd0;
      bitpos_q <= 3'd0;
    end else if (en) begin
      st_q     <= flush ? CS_IDLE : st_d;
      zrun_q   <= flush ? 2'd0 : zrun_d;
      bitpos_q <= bitpos_d;
    end
  end

  assert_found_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    found |=> (bitpos_q == 3'd0 && !seeking));

  assert_halt_no_move_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !seeking) |-> (shamt == '0));
endmodule

// File: rtl/bsw_status.sv
module bsw_status #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_we,
  input  logic [N-1:0] clr,
  input  logic         ien_we,
  input  logic [N-1:0] ien_wdata,
  output logic [N-1:0] sts,
  output logic         irq
);
  logic [N-1:0] sts_q, sts_d, ien_q, ien_d;
  logic         sts_en, ien_en;

  always_comb begin
    sts_d  = (sts_q & ~(clr_we ? clr : '0)) | set;
    sts_en = clr_we | (|set);
    ien_d  = ien_wdata;
    ien_en = ien_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      ien_q <= '0;
    end else begin
      if (sts_en) sts_q <= sts_d;
      if (ien_en) ien_q <= ien_d;
    end
  end

  assign sts = sts_q;
  assign irq = |(sts_q & ien_q);

  assert_irq_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(set & ien_q)) && !ien_we) |=> irq);

  assert_mask_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);

  assert_set_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((sts_q & $past(set)) == $past(set)));
endmodule

// File: rtl/bitstream_window.sv
module bitstream_window
  import bsw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int BUF_W  = 32,
  parameter int WIN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [4:0]        cmd_bits,
  input  logic              sts_clr_we,
  input  logic [2:0]        sts_clr,
  input  logic              ien_we,
  input  logic [2:0]        ien_wdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic [7:0]        mem_byte,
  output logic [WIN_W-1:0]  win_data,
  output logic              win_full,
  output logic              seek_busy,
  output logic [2:0]        status,
  output logic              irq
);
  localparam int SHW       = $clog2(WIN_W + 1);
  localparam int FILL_W    = $clog2(BUF_W + 1);
  localparam int REFILL_TH = BUF_W - 8;

  logic [FILL_W-1:0] fill;
  logic [SHW-1:0]    shamt;
  logic [7:0]        top_byte;
  logic              want, take, empty, drained;
  logic              found, stall_evt;
  logic [ST_N-1:0]   set_v;

  assign want     = (fill < FILL_W'(REFILL_TH));
  assign win_full = (fill >= FILL_W'(WIN_W));

  bsw_fetch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .load_addr(cfg_addr),
    .load_len(cfg_len), .want(want), .mem_gnt(mem_gnt), .mem_req(mem_req),
    .mem_addr(mem_addr), .take(take), .empty(empty), .drained(drained)
  );

  bsw_holdbuf #(.BUF_W(BUF_W), .WIN_W(WIN_W), .SHW(SHW), .FILL_W(FILL_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .flush(cfg_load), .shamt(shamt),
    .append(take), .byte_in(mem_byte), .win(win_data), .top_byte(top_byte),
    .fill(fill)
  );

  bsw_ctrl #(.WIN_W(WIN_W), .SHW(SHW), .FILL_W(FILL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(cfg_load), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_bits(SHW'(cmd_bits)), .fill(fill),
    .top_byte(top_byte), .halted(status[ST_SC]), .empty(empty),
    .shamt(shamt), .found(found), .seeking(seek_busy), .stall_evt(stall_evt)
  );

  always_comb begin
    set_v           = '0;
    set_v[ST_SC]    = found;
    set_v[ST_DONE]  = drained;
    set_v[ST_STALL] = stall_evt;
  end

  bsw_status #(.N(ST_N)) u_sts (
    .clk(clk), .rst_n(rst_n), .set(set_v), .clr_we(sts_clr_we),
    .clr(sts_clr), .ien_we(ien_we), .ien_wdata(ien_wdata),
    .sts(status), .irq(irq)
  );

  assert_req_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (fill < FILL_W'(REFILL_TH)));

  assert_halt_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    status[ST_SC] |-> !seek_busy);

  assert_done_on_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drained |=> status[ST_DONE]);
endmodule

// File: tb/test_bitstream_window.sv
module test_bitstream_window;
  logic        clk, rst_n;
  logic        cfg_load;
  logic [31:0] cfg_addr;
  logic [15:0] cfg_len;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [4:0]  cmd_bits;
  logic        sts_clr_we;
  logic [2:0]  sts_clr;
  logic        ien_we;
  logic [2:0]  ien_wdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_gnt;
  logic [7:0]  mem_byte;
  logic [15:0] win_data;
  logic        win_full, seek_busy, irq;
  logic [2:0]  status;

  int nchk = 0, nfail = 0, nacc = 0, gcnt = 0, pos = 0;
  logic [31:0] base_r = 32'h100;

  bitstream_window i_bitstream_window (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_addr(cfg_addr),
    .cfg_len(cfg_len), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bits(cmd_bits), .sts_clr_we(sts_clr_we), .sts_clr(sts_clr),
    .ien_we(ien_we), .ien_wdata(ien_wdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_byte(mem_byte),
    .win_data(win_data), .win_full(win_full), .seek_busy(seek_busy),
    .status(status), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] sbyte(int i);
    case (i)
      20, 21, 40, 41, 50, 51, 52: return 8'h00;
      22, 42, 53:                 return 8'h01;
      23:                         return 8'hB5;
      43:                         return 8'h2A;
      54:                         return 8'h77;
      default:                    return 8'((i * 37 + 11) & 255);
    endcase
  endfunction

  function automatic logic [15:0] expwin(int p);
    logic [15:0] w;
    for (int k = 0; k < 16; k++) begin
      logic [7:0] b;
      b = sbyte((p + k) / 8);
      w[15 - k] = b[7 - ((p + k) % 8)];
    end
    return w;
  endfunction

  function automatic int seek_model(int p);
    int q, z;
    q = (p + 7) / 8;
    z = 0;
    for (int guard = 0; guard < 1000; guard++) begin
      if (z >= 2 && sbyte(q) == 8'h01) return (q + 1) * 8;
      z = (sbyte(q) == 8'h00) ? z + 1 : 0;
      q++;
    end
    return -1;
  endfunction

  assign mem_byte = sbyte(int'(mem_addr - base_r));

  always @(negedge clk) begin
    gcnt    <= gcnt + 1;
    mem_gnt <= ((gcnt % 3) != 2);
  end

  always @(posedge clk) begin
    if (!rst_n || cfg_load) nacc <= 0;
    else if (mem_req && mem_gnt) nacc <= nacc + 1;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_full();
    while (!win_full) @(negedge clk);
  endtask

  task automatic send(logic [1:0] op, int n);
    cmd_valid = 1'b1; cmd_op = op; cmd_bits = 5'(n);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd0; cmd_bits = 5'd0;
  endtask

  task automatic clear(logic [2:0] m);
    sts_clr_we = 1'b1; sts_clr = m;
    @(negedge clk);
    sts_clr_we = 1'b0; sts_clr = 3'd0;
  endtask

  task automatic set_ien(logic [2:0] m);
    ien_we = 1'b1; ien_wdata = m;
    @(negedge clk);
    ien_we = 1'b0;
  endtask

  task automatic load(logic [31:0] a, logic [15:0] n);
    cfg_load = 1'b1; cfg_addr = a; cfg_len = n; base_r = a;
    @(negedge clk);
    cfg_load = 1'b0;
    pos = 0;
  endtask

  task automatic seek_and_check(string tag);
    send(2'd2, 0);
    while (!status[0]) @(negedge clk);
    pos = seek_model(pos);
    chk({tag, " R4 busy"}, 32'(seek_busy), 32'd0);
    wait_full();
    chk({tag, " R4 value byte"}, 32'(win_data[15:8]), 32'(sbyte(pos / 8)));
    chk({tag, " R3 window"}, 32'(win_data), 32'(expwin(pos)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_load = 1'b0; cfg_addr = '0; cfg_len = '0;
    cmd_valid = 1'b0; cmd_op = '0; cmd_bits = '0;
    sts_clr_we = 1'b0; sts_clr = '0; ien_we = 1'b0; ien_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset status", 32'(status), 32'd0);
    chk("R6 reset irq", 32'(irq), 32'd0);
    chk("R8 reset no request", 32'(mem_req), 32'd0);
    chk("R1 reset window empty", 32'(win_full), 32'd0);

    load(32'h100, 16'd64);
    wait_full();
    chk("R1 first window", 32'(win_data), 32'(expwin(0)));
    chk("R9 address tracks bytes", mem_addr, 32'h100 + 32'(nacc));

    for (int n = 0; n <= 16; n++) begin
      wait_full();
      send(2'd1, n);
      pos += n;
      wait_full();
      chk("R2 shift sweep", 32'(win_data), 32'(expwin(pos)));
    end
    send(2'd1, 20);
    wait_full();
    chk("R2 oversize shift ignored", 32'(win_data), 32'(expwin(pos)));
    chk("R9 address after sweep", mem_addr, 32'h100 + 32'(nacc));

    set_ien(3'b111);
    seek_and_check("aligned seek");
    chk("R6 irq on start code", 32'(irq), 32'd1);

    send(2'd1, 5);
    @(negedge clk);
    chk("R5 shift while halted", 32'(win_data), 32'(expwin(pos)));
    send(2'd2, 0);
    @(negedge clk);
    chk("R5 seek while halted", 32'(seek_busy), 32'd0);
    chk("R5 window kept", 32'(win_data), 32'(expwin(pos)));

    clear(3'b001);
    chk("R6 clear start code", 32'(status[0]), 32'd0);
    chk("R6 irq drops", 32'(irq), 32'd0);

    send(2'd1, 3);
    pos += 3;
    seek_and_check("unaligned seek");
    clear(3'b001);
    set_ien(3'b000);

    wait_full();
    send(2'd1, 5);
    pos += 5;
    seek_and_check("long zero run seek");
    chk("R6 masked irq", 32'(irq), 32'd0);
    clear(3'b001);

    for (int n = 0; n < 5; n++) begin
      wait_full();
      send(2'd1, 16);
      pos += 16;
      if (n < 4) begin
        wait_full();
        chk("R1 drain window", 32'(win_data), 32'(expwin(pos)));
      end
    end
    @(negedge clk);
    chk("R7 input done", 32'(status[1]), 32'd1);
    chk("R1 window not full", 32'(win_full), 32'd0);
    chk("R10 no stall yet", 32'(status[2]), 32'd0);
    chk("R9 final address", mem_addr, 32'h100 + 32'd64);

    set_ien(3'b100);
    send(2'd1, 4);
    chk("R10 stall flag", 32'(status[2]), 32'd1);
    chk("R6 stall irq", 32'(irq), 32'd1);

    load(32'h100, 16'd64);
    wait_full();
    chk("R7 reload window", 32'(win_data), 32'(expwin(0)));
    chk("R9 reload address", mem_addr, 32'h100 + 32'(nacc));
    send(2'd1, 3);
    pos = 3;
    seek_and_check("reload seek");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule